// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block converts an instruction fetch address into a physical address. It takes the result of a translation buffer lookup that happens outside the block, and it decides the outcome of the fetch. Four address forms are recognised. A fetch address with bit 0 set is privileged code: it bypasses translation and needs no permission check. A physical-mode fetch passes the address through unchanged. A kernel-only superpage window maps straight to physical space, with sign extension of the upper physical bits. Every other fetch uses the translation entry: its page number, plus an execute-enable mask with one bit per privilege mode.

A request presented with `req_valid` is classified combinationally, and the result is registered. The physical address and the fault kind appear one cycle later with `resp_valid`. On a miss or an access violation, two fault registers are captured unless the fetch is speculative. The first records the faulting address. The second records a page-table pointer, formed from a base input and the virtual page number. The translation storage and the refill handler sit outside this block.

Top module: `itx_fetch_xlate`

## Requirements
- R1: While reset is held and on the first cycle after its release, `resp_valid`, `pa`, `fault_kind`, `fault_tag` and `fault_form` are all zero.
- R2: If bit 0 of `fetch_va` is set, `pa` is `fetch_va` with bits 1:0 cleared and bits 63:44 cleared, and `fault_kind` is 0 (none). This holds whatever the mode, the TLB inputs or `phys_mode` are.
- R3: Otherwise, when `phys_mode` is 1, `pa` equals `fetch_va`.
- R4: Otherwise, a `fetch_va` whose bits 63:48 are not all equal to bit 47 gives `fault_kind` 2 (access violation).
- R5: Otherwise, `fetch_va[47:41]` equal to 7'h7e selects the superpage. If `cur_mode` is not 0 (kernel), the result is `fault_kind` 2.
- R6: A superpage fetch in kernel mode gives `pa` equal to `fetch_va[43:0]` with bits 43:40 forced to ones when bit 40 is set. When bit 40 is clear, `pa` keeps only bits 39:0. The fault kind is 0.
- R7: Otherwise, `tlb_hit` equal to 0 gives `fault_kind` 1 (miss) and `pa` 0.
- R8: On a TLB hit, `pa` is `tlb_ppn` shifted left by 13, plus `fetch_va[12:0]` with bits 1:0 cleared.
- R9: On a TLB hit where bit `cur_mode` of `tlb_exec_en` is 0, the result is `fault_kind` 2 and `pa` 0.
- R10: When a response is a miss or an access violation and `spec` was 0, `fault_tag` takes `fetch_va`. In the same cycle, `fault_form` takes `pt_base | (fetch_va[47:13] << 3)`. In every other case, both registers hold their values.
- R11: When no other fault occurs and the final `pa` has any bit of 63:44 set, `fault_kind` is 3 (machine check), `pa` shows the address, and the fault registers hold.
- R12: `resp_valid` is high exactly in the cycle after a cycle with `req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request present |
| fetch_va | input | 64 | Fetch virtual address |
| phys_mode | input | 1 | Fetch uses physical addressing |
| cur_mode | input | 2 | Current privilege mode, 0 is kernel |
| spec | input | 1 | Fetch is speculative; fault registers are not updated |
| tlb_hit | input | 1 | Lookup found an entry |
| tlb_ppn | input | 32 | Physical page number of the entry |
| tlb_exec_en | input | 4 | Execute enable, one bit per mode |
| pt_base | input | 64 | Page-table base for the formatted fault address |
| resp_valid | output | 1 | Result valid |
| pa | output | 64 | Physical address |
| fault_kind | output | 2 | 0 none, 1 miss, 2 access violation, 3 machine check |
| fault_tag | output | 64 | Last faulting fetch address |
| fault_form | output | 64 | Last formatted page-table fault address |

## Verification
The bench first probes the order of precedence. It sends a privileged-code fetch with high garbage bits while the TLB reports a miss; a design that checked the TLB first would report a miss instead of a clean hit. Next come superpage fetches on both sides of bit 40. Swapping the sign-extension arms, or allowing user mode into the window, shows up as a wrong address or a missing violation. Last, it issues a speculative miss and a machine check after a captured fault, and the fault registers must keep their older contents.

// File: rtl/itx_pkg.sv
package itx_pkg;

  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_MISS = 2'd1,
    FK_ACV  = 2'd2,
    FK_MCHK = 2'd3
  } fault_e;

  localparam logic [6:0] SP_TAG    = 7'h7e;
  localparam int         SP_SIGN   = 40;
  localparam int         FORM_SHL  = 3;

  function automatic logic [63:0] low_mask(input int w);
    return (64'd1 << w) - 64'd1;
  endfunction

  function automatic logic canonical(input logic [63:0] va, input int impl);
    logic ok;
    ok = 1'b1;
    for (int i = impl; i < 64; i++)
      if (va[i] != va[impl-1]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [63:0] sp_extend(input logic [63:0] pa, input int pa_w);
    if (pa[SP_SIGN])
      return pa | (low_mask(pa_w) & ~low_mask(SP_SIGN));
    return pa & low_mask(SP_SIGN);
  endfunction

  function automatic logic [63:0] form_addr(input logic [63:0] base, input logic [63:0] va,
                                            input int va_impl, input int pg);
    logic [63:0] vpn;
    vpn = (va & low_mask(va_impl)) >> pg;
    return base | (vpn << FORM_SHL);
  endfunction

endpackage

// File: rtl/itx_classify.sv
module itx_classify
  import itx_pkg::*;
#(
  parameter int PA_W     = 44,
  parameter int VA_IMPL  = 48,
  parameter int PG_SHIFT = 13,
  parameter int PPN_W    = 32,
  parameter int MODE_W   = 2
) (
  input  logic [63:0]             va,
  input  logic                    phys_mode,
  input  logic [MODE_W-1:0]       mode,
  input  logic                    tlb_hit,
  input  logic [PPN_W-1:0]        ppn,
  input  logic [(1<<MODE_W)-1:0]  xen,
  output logic [63:0]             pa_n,
  output fault_e                  kind_n,
  output logic                    ev_pal,
  output logic                    ev_canon,
  output logic                    ev_super,
  output logic                    ev_raise
);
  localparam logic [63:0] PMASK = low_mask(PA_W);

  logic [63:0] pa_raw;
  fault_e      kind_pre;

  assign ev_pal   = va[0];
  assign ev_canon = canonical(va, VA_IMPL);
  assign ev_super = (va[VA_IMPL-1 -: 7] == SP_TAG);

  always_comb begin
    pa_raw   = '0;
    kind_pre = FK_NONE;
    if (ev_pal) begin
      pa_raw = va & ~64'd3 & PMASK;
    end else if (phys_mode) begin
      pa_raw = va;
    end else if (!ev_canon) begin
      kind_pre = FK_ACV;
    end else if (ev_super) begin
      if (mode != '0) kind_pre = FK_ACV;
      else            pa_raw   = sp_extend(va & PMASK, PA_W);
    end else if (!tlb_hit) begin
      kind_pre = FK_MISS;
    end else begin
      pa_raw = (64'(ppn) << PG_SHIFT) + 64'({va[PG_SHIFT-1:2], 2'b00});
      if (!xen[mode]) kind_pre = FK_ACV;
    end
  end

  always_comb begin
    kind_n = kind_pre;
    if (kind_pre == FK_NONE && (pa_raw & ~PMASK) != '0) kind_n = FK_MCHK;
  end

  assign ev_raise = (kind_n == FK_MISS) || (kind_n == FK_ACV);
  assign pa_n     = ev_raise ? '0 : pa_raw;

endmodule

// File: rtl/itx_fault_regs.sv
module itx_fault_regs
  import itx_pkg::*;
#(
  parameter int VA_IMPL  = 48,
  parameter int PG_SHIFT = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        raise_req,
  input  logic        spec,
  input  logic [63:0] va,
  input  logic [63:0] base,
  output logic [63:0] tag_q,
  output logic [63:0] form_q
);
  logic capture;
  assign capture = raise_req && !spec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q  <= '0;
      form_q <= '0;
    end else if (capture) begin
      tag_q  <= va;
      form_q <= form_addr(base, va, VA_IMPL, PG_SHIFT);
    end
  end

  // R10: speculative faults leave both registers alone
  p_spec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_req && spec) |=> ($stable(tag_q) && $stable(form_q)));

  // R10: non-speculative fault records the address
  p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_req && !spec) |=> (tag_q == $past(va)));

  // R10: no fault, no change
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !raise_req |=> ($stable(tag_q) && $stable(form_q)));

endmodule

// File: rtl/itx_fetch_xlate.sv
module itx_fetch_xlate
  import itx_pkg::*;
#(
  parameter int PA_W     = 44,
  parameter int VA_IMPL  = 48,
  parameter int PG_SHIFT = 13,
  parameter int PPN_W    = 32,
  parameter int MODE_W   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [63:0]            fetch_va,
  input  logic                   phys_mode,
  input  logic [MODE_W-1:0]      cur_mode,
  input  logic                   spec,
  input  logic                   tlb_hit,
  input  logic [PPN_W-1:0]       tlb_ppn,
  input  logic [(1<<MODE_W)-1:0] tlb_exec_en,
  input  logic [63:0]            pt_base,
  output logic                   resp_valid,
  output logic [63:0]            pa,
  output logic [1:0]             fault_kind,
  output logic [63:0]            fault_tag,
  output logic [63:0]            fault_form
);
  logic [63:0] pa_n;
  fault_e      kind_n;
  logic        ev_pal, ev_canon, ev_super, ev_raise;

  itx_classify #(
    .PA_W(PA_W), .VA_IMPL(VA_IMPL), .PG_SHIFT(PG_SHIFT),
    .PPN_W(PPN_W), .MODE_W(MODE_W)
  ) u_cls (
    .va(fetch_va), .phys_mode(phys_mode), .mode(cur_mode), .tlb_hit(tlb_hit),
    .ppn(tlb_ppn), .xen(tlb_exec_en), .pa_n(pa_n), .kind_n(kind_n),
    .ev_pal(ev_pal), .ev_canon(ev_canon), .ev_super(ev_super), .ev_raise(ev_raise)
  );

  itx_fault_regs #(.VA_IMPL(VA_IMPL), .PG_SHIFT(PG_SHIFT)) u_fr (
    .clk(clk), .rst_n(rst_n), .raise_req(req_valid && ev_raise), .spec(spec),
    .va(fetch_va), .base(pt_base), .tag_q(fault_tag), .form_q(fault_form)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      pa         <= '0;
      fault_kind <= FK_NONE;
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        pa         <= pa_n;
        fault_kind <= kind_n;
      end
    end
  end

  // R12: one-cycle response
  p_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  p_noresp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  // R2: privileged-code fetch never faults
  p_pal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fetch_va[0]) |=> (fault_kind == FK_NONE));

  // R5: superpage outside kernel is a violation
  p_super_user_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ev_pal && !phys_mode && ev_canon && ev_super && cur_mode != '0)
    |=> (fault_kind == FK_ACV));

  // R7: a translated fetch with no entry is a miss
  p_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ev_pal && !phys_mode && ev_canon && !ev_super && !tlb_hit)
    |=> (fault_kind == FK_MISS && pa == '0));

  // R11: machine check only for out-of-range addresses
  p_mchk_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && fault_kind == FK_MCHK) |-> ((pa >> PA_W) != '0));

endmodule

// File: tb/sim_itx_fetch_xlate.sv
module sim_itx_fetch_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] fetch_va = '0;
  logic        phys_mode = 1'b0;
  logic [1:0]  cur_mode = '0;
  logic        spec = 1'b0;
  logic        tlb_hit = 1'b0;
  logic [31:0] tlb_ppn = '0;
  logic [3:0]  tlb_exec_en = '0;
  logic [63:0] pt_base = '0;
  logic        resp_valid;
  logic [63:0] pa, fault_tag, fault_form;
  logic [1:0]  fault_kind;

  int total = 0, bad = 0, cyc = 0;
  bit checking = 1'b0;
  string cur_tag = "R12", exp_tag = "R12";

  logic        e_valid = 1'b0;
  logic [63:0] e_pa = '0, e_tag = '0, e_form = '0;
  logic [1:0]  e_kind = '0;

  always #5 clk = ~clk;

  itx_fetch_xlate u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .fetch_va(fetch_va),
    .phys_mode(phys_mode), .cur_mode(cur_mode), .spec(spec), .tlb_hit(tlb_hit),
    .tlb_ppn(tlb_ppn), .tlb_exec_en(tlb_exec_en), .pt_base(pt_base),
    .resp_valid(resp_valid), .pa(pa), .fault_kind(fault_kind),
    .fault_tag(fault_tag), .fault_form(fault_form)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, want);
    end
  endtask

  // behavioural reference, restated from the requirements
  task automatic ref_xlate(output logic [63:0] rpa, output logic [1:0] rk);
    logic [63:0] lim;
    bit hi_ok;
    lim = 64'h0000_0FFF_FFFF_FFFF;
    rpa = 0; rk = 0;
    hi_ok = (fetch_va[63:47] == '0) || (fetch_va[63:47] == '1);
    if (fetch_va[0] == 1'b1) begin
      rpa = {fetch_va[63:2], 2'b00} & lim;
      return;
    end
    if (phys_mode) rpa = fetch_va;
    else if (!hi_ok) rk = 2;
    else if (fetch_va[47:41] == 7'b1111110) begin
      if (cur_mode != 0) rk = 2;
      else if (fetch_va[40]) rpa = {20'h0, 4'hF, fetch_va[39:0]};
      else rpa = {24'h0, fetch_va[39:0]};
    end else if (!tlb_hit) rk = 1;
    else if (tlb_exec_en[cur_mode] == 1'b0) rk = 2;
    else rpa = {19'h0, tlb_ppn, 13'h0} + {51'h0, fetch_va[12:2], 2'b00};
    if (rk == 0 && rpa[63:44] != 0) rk = 3;
  endtask

  always @(posedge clk) begin
    logic [63:0] rpa; logic [1:0] rk;
    if (!rst_n) begin
      e_valid = 0; e_pa = 0; e_kind = 0; e_tag = 0; e_form = 0;
    end else begin
      e_valid = req_valid;
      if (req_valid) begin
        ref_xlate(rpa, rk);
        e_pa = rpa; e_kind = rk; exp_tag = cur_tag;
        if ((rk == 1 || rk == 2) && !spec) begin
          e_tag  = fetch_va;
          e_form = pt_base | ({16'h0, fetch_va[47:0]} >> 13 << 3);
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (checking) begin
      check("R12", "resp_valid", {63'h0, resp_valid}, {63'h0, e_valid});
      if (e_valid) begin
        check(exp_tag, "pa", pa, e_pa);
        check(exp_tag, "fault_kind", {62'h0, fault_kind}, {62'h0, e_kind});
      end
      check("R10", "fault_tag", fault_tag, e_tag);
      check("R10", "fault_form", fault_form, e_form);
    end
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic issue(input string tag, input logic [63:0] va, input logic ph,
                       input logic [1:0] md, input logic hit, input logic [31:0] ppn,
                       input logic [3:0] xen, input logic sp, input logic [63:0] base);
    @(negedge clk);
    cur_tag = tag; req_valid = 1; fetch_va = va; phys_mode = ph; cur_mode = md;
    tlb_hit = hit; tlb_ppn = ppn; tlb_exec_en = xen; spec = sp; pt_base = base;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur_tag = "R12"; req_valid = 0; fetch_va = 64'hDEAD_BEEF_0000_0001;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "resp_valid", {63'h0, resp_valid}, 64'h0);
    check("R1", "pa", pa, 64'h0);
    check("R1", "fault_kind", {62'h0, fault_kind}, 64'h0);
    check("R1", "fault_tag", fault_tag, 64'h0);
    check("R1", "fault_form", fault_form, 64'h0);
    rst_n = 1;
    checking = 1;
    // R2: privileged code, even with a miss and user mode and high bits
    issue("R2", 64'hFFFF_F123_4567_89AB, 0, 3, 0, 0, 4'h0, 0, 64'h0);
    issue("R2", 64'h0000_0000_0040_0003, 1, 2, 0, 0, 4'h0, 0, 64'h0);
    // R3: physical mode passthrough
    issue("R3", 64'h0000_0ABC_DEF0_1234, 1, 1, 0, 0, 4'h0, 0, 64'h0);
    // R11: physical mode above implemented width
    issue("R11", 64'h0001_0000_0000_0000, 1, 0, 0, 0, 4'h0, 0, 64'h0);
    // R4: non-canonical translated fetch, captured
    issue("R4", 64'h0001_0000_0000_2000, 0, 0, 1, 32'h1, 4'hF, 0, 64'h1_0000_0000);
    // R5: superpage from user mode
    issue("R5", 64'hFFFF_FC00_0000_4000, 0, 3, 1, 32'h1, 4'hF, 0, 64'h2_0000_0000);
    // R6: superpage kernel, bit 40 set and clear
    issue("R6", 64'hFFFF_FD12_3456_789C, 0, 0, 0, 0, 4'h0, 0, 64'h0);
    issue("R6", 64'hFFFF_FC12_3456_7898, 0, 0, 0, 0, 4'h0, 0, 64'h0);
    // R7: miss, captured; then speculative miss must not capture (R10)
    issue("R7", 64'h0000_1234_5678_A000, 0, 1, 0, 0, 4'h0, 0, 64'h3_0000_0000);
    issue("R10", 64'h0000_0000_7777_0000, 0, 1, 0, 0, 4'h0, 1, 64'h4_0000_0000);
    // R8: hit, offset low bits cleared
    issue("R8", 64'h0000_0000_0246_1FFF & ~64'h1, 0, 1, 1, 32'h0000_1234, 4'b0010, 0, 64'h0);
    issue("R8", 64'hFFFF_8000_0000_0006, 0, 0, 1, 32'h0ABC_DEF0, 4'b0001, 0, 64'h0);
    // R9: execute not enabled in this mode
    issue("R9", 64'h0000_0000_0008_0010, 0, 2, 1, 32'h55, 4'b1011, 0, 64'h5_0000_0000);
    // R11: hit with oversize page number, fault regs hold
    issue("R11", 64'h0000_0000_0000_2004, 0, 0, 1, 32'hFFFF_FFFF, 4'hF, 0, 64'h6_0000_0000);
    // R12: idle then back to back
    idle(3);
    issue("R8", 64'h0000_0000_0000_4010, 0, 3, 1, 32'h7, 4'b1000, 0, 64'h0);
    issue("R7", 64'h0000_0000_0000_6000, 0, 3, 0, 0, 4'h0, 0, 64'h7_0000_0000);
    idle(3);
    checking = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule